// File: doc/BRIEF.md
# Bridge Control and Status Register with Access Timeout

This block holds one 16-bit control and status word for a peripheral bus bridge and watches each bridge access for a timeout. The word carries a 7-bit timeout limit, two 3-bit wait-state counts (one for each of two strobes), a priority-select bit, a sticky bus-error flag and a read-only access-mode bit. The field values are exported as plain levels, so external strobe generators and an external arbiter can use them directly.

Two ports reach the word. The primary CPU port reads and writes it. A read on this port also clears the error flag. The secondary host port can only read the word. Host write strobes are accepted but change nothing.

The timeout monitor restarts on each access start and counts strobe ticks. When the count equals the programmed limit, it raises a bus error and stops counting. A mode-change error input raises a bus error in the same way. Every error event sets the sticky flag and also produces a one-cycle error pulse.

Top module: `bridge_ctl_reg`

## Requirements
- R1: After reset the word reads 0xFE4D on both ports. The outputs show timeout limit 0x7F, both wait-state counts 1, priority 1, error flag 0 and error pulse 0.
- R2: The word layout is fixed. Bits 15:9 hold the timeout limit, bits 8:6 the strobe-2 wait count, bits 5:3 the strobe-1 wait count, bit 2 priority, bit 1 bus error and bit 0 mode. A CPU write (cpuSel=1, cpuWr=1) loads bits 15:2, and the exported fields show the new values after that clock edge.
- R3: CPU writes to bits 1:0 are ignored. Neither the error flag nor the mode bit changes.
- R4: Host write strobes (hostSel=1, hostWr=1) change no field, and later reads return the same word.
- R5: The mode bit (bit 0) is a registered copy of modeHostOnly. It reflects the value sampled at the previous clock edge, and 1 means host-only mode.
- R6: With limit N, after accStart and N strobe ticks, the flag and the pulse both rise one cycle after the count reaches N. A limit of 0 fires in the cycle that follows accStart, with no tick.
- R7: accDone before the count reaches the limit ends the access, and no error is raised.
- R8: A cycle with modeChgErr=1 sets the flag and the pulse at the next edge.
- R9: A CPU read (cpuSel=1, cpuWr=0) returns the current word and clears the error flag at the end of that cycle.
- R10: If an error event and a clearing CPU read fall in the same cycle, the flag stays set.
- R11: While the mode bit is 1, bit 1 reads as 0 on both ports, even when the flag itself is set.
- R12: The error pulse lasts one cycle for each isolated error event, and the flag stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSel | input | 1 | Primary CPU access strobe |
| cpuWr | input | 1 | Primary CPU write (1) or read (0) |
| cpuWdata | input | 16 | Primary CPU write data |
| cpuRdata | output | 16 | Word during a CPU read, otherwise 0 |
| hostSel | input | 1 | Host access strobe |
| hostWr | input | 1 | Host write strobe (no effect) |
| hostRdata | output | 16 | Word during a host read, otherwise 0 |
| modeHostOnly | input | 1 | Current access mode from the host interface |
| accStart | input | 1 | A bridge access begins |
| strobeTick | input | 1 | One strobe cycle of the outstanding access |
| accDone | input | 1 | The outstanding access completed |
| modeChgErr | input | 1 | Error during an access-mode change |
| timeoutLimit | output | 7 | Timeout field |
| waitStrobe2 | output | 3 | Strobe-2 wait-state field |
| waitStrobe1 | output | 3 | Strobe-1 wait-state field |
| cpuPriority | output | 1 | Priority select level for the arbiter |
| busErr | output | 1 | Sticky error flag (not masked by mode) |
| errPulse | output | 1 | One-cycle error indication |

## Verification
The timeout monitor is run three ways: a nonzero limit reached by exact ticks, a zero limit that fires with no tick, and an access completed before the limit. Together these separate an off-by-one compare, a counter that keeps running past the limit, and a completion that fails to cancel the access. Error events are applied both alone and together with a clearing read, which shows whether set or clear takes precedence. Mode-masked reads are taken on the host port with the flag known to be set, so the masking is seen apart from the clear-on-read side effect.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  parameter int TO_W = 7;
  parameter int WS_W = 3;
  localparam int REG_W  = TO_W + 2 * WS_W + 3;
  localparam int MODE_B = 0;
  localparam int ERR_B  = 1;
  localparam int PRI_B  = 2;
  localparam int WS1_LO = 3;
  localparam int WS2_LO = WS1_LO + WS_W;
  localparam int TO_LO  = WS2_LO + WS_W;

  typedef struct packed {
    logic rdClr;
    logic wrEn;
    logic errSet;
  } bcrStrobes_t;
endpackage

// File: rtl/bcr_ctl.sv
module bcr_ctl
  import bcr_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cpuSel,
  input  logic            cpuWr,
  input  logic            accStart,
  input  logic            strobeTick,
  input  logic            accDone,
  input  logic            modeChgErr,
  input  logic [TO_W-1:0] limit,
  output bcrStrobes_t     strobes,
  output logic            toHit
);
  logic            active;
  logic [TO_W-1:0] count;

  // Timeout fires once when the count meets the limit of a live access
  assign toHit = active && (count == limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      count  <= '0;
    end else if (accStart) begin
      active <= 1'b1;
      count  <= '0;
    end else if (active) begin
      if (toHit || accDone) begin
        active <= 1'b0;
      end else if (strobeTick) begin
        count <= count + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.rdClr  = cpuSel && !cpuWr;
    strobes.wrEn   = cpuSel && cpuWr;
    strobes.errSet = toHit || modeChgErr;
  end
endmodule

// File: rtl/bcr_dp.sv
module bcr_dp
  import bcr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  bcrStrobes_t      strobes,
  input  logic [REG_W-1:0] wdata,
  input  logic             modeHostOnly,
  output logic [REG_W-1:0] rdWord,
  output logic [TO_W-1:0]  toLimit,
  output logic [WS_W-1:0]  ws2,
  output logic [WS_W-1:0]  ws1,
  output logic             pri,
  output logic             errFlag,
  output logic             errPulse
);
  localparam logic [TO_W-1:0] RST_TO  = '1;
  localparam logic [WS_W-1:0] RST_WS  = WS_W'(1);

  logic       modeReg;
  logic [1:0] wdataUnused;

  // Status bits are not writable
  assign wdataUnused = wdata[ERR_B:MODE_B];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toLimit  <= RST_TO;
      ws2      <= RST_WS;
      ws1      <= RST_WS;
      pri      <= 1'b1;
      errFlag  <= 1'b0;
      modeReg  <= 1'b1;
      errPulse <= 1'b0;
    end else begin
      modeReg  <= modeHostOnly;
      errPulse <= strobes.errSet;
      if (strobes.wrEn) begin
        toLimit <= wdata[TO_LO +: TO_W];
        ws2     <= wdata[WS2_LO +: WS_W];
        ws1     <= wdata[WS1_LO +: WS_W];
        pri     <= wdata[PRI_B];
      end
      if (strobes.errSet) begin
        errFlag <= 1'b1;
      end else if (strobes.rdClr) begin
        errFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    rdWord               = '0;
    rdWord[TO_LO +: TO_W]  = toLimit;
    rdWord[WS2_LO +: WS_W] = ws2;
    rdWord[WS1_LO +: WS_W] = ws1;
    rdWord[PRI_B]        = pri;
    rdWord[ERR_B]        = errFlag && !modeReg;
    rdWord[MODE_B]       = modeReg;
  end
endmodule

// File: rtl/bridge_ctl_reg.sv
module bridge_ctl_reg
  import bcr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuSel,
  input  logic             cpuWr,
  input  logic [REG_W-1:0] cpuWdata,
  output logic [REG_W-1:0] cpuRdata,
  input  logic             hostSel,
  input  logic             hostWr,
  output logic [REG_W-1:0] hostRdata,
  input  logic             modeHostOnly,
  input  logic             accStart,
  input  logic             strobeTick,
  input  logic             accDone,
  input  logic             modeChgErr,
  output logic [TO_W-1:0]  timeoutLimit,
  output logic [WS_W-1:0]  waitStrobe2,
  output logic [WS_W-1:0]  waitStrobe1,
  output logic             cpuPriority,
  output logic             busErr,
  output logic             errPulse
);
  bcrStrobes_t      strobes;
  logic             toHit;
  logic [REG_W-1:0] rdWord;

  bcr_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuSel     (cpuSel),
    .cpuWr      (cpuWr),
    .accStart   (accStart),
    .strobeTick (strobeTick),
    .accDone    (accDone),
    .modeChgErr (modeChgErr),
    .limit      (timeoutLimit),
    .strobes    (strobes),
    .toHit      (toHit)
  );

  bcr_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .wdata        (cpuWdata),
    .modeHostOnly (modeHostOnly),
    .rdWord       (rdWord),
    .toLimit      (timeoutLimit),
    .ws2          (waitStrobe2),
    .ws1          (waitStrobe1),
    .pri          (cpuPriority),
    .errFlag      (busErr),
    .errPulse     (errPulse)
  );

  assign cpuRdata  = (cpuSel && !cpuWr) ? rdWord : '0;
  assign hostRdata = (hostSel && !hostWr) ? rdWord : '0;
endmodule

// File: rtl/bridge_ctl_reg_chk.sv
module bridge_ctl_reg_chk
  import bcr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cpuSel,
  input logic             cpuWr,
  input logic             hostSel,
  input logic             hostWr,
  input logic [REG_W-1:0] cpuRdata,
  input logic [REG_W-1:0] hostRdata,
  input logic             modeHostOnly,
  input logic             modeChgErr,
  input logic             toHit,
  input logic [TO_W-1:0]  timeoutLimit,
  input logic [WS_W-1:0]  waitStrobe2,
  input logic [WS_W-1:0]  waitStrobe1,
  input logic             cpuPriority,
  input logic             busErr,
  input logic             errPulse
);
  p_host_ro_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && hostWr && !(cpuSel && cpuWr)) |=>
      ($stable(timeoutLimit) && $stable(waitStrobe2) &&
       $stable(waitStrobe1) && $stable(cpuPriority)));

  p_mode_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && !hostWr) |-> (hostRdata[MODE_B] == $past(modeHostOnly)));

  p_hit_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    toHit |=> (busErr && errPulse));

  p_mode_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    modeChgErr |=> (busErr && errPulse));

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && !cpuWr && !modeChgErr && !toHit) |=> !busErr);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && !cpuWr && modeChgErr) |=> busErr);

  p_mask_cpu_r11: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdata[MODE_B] |-> !cpuRdata[ERR_B]);

  p_mask_host_r11: assert property (@(posedge clk) disable iff (!rstN)
    hostRdata[MODE_B] |-> !hostRdata[ERR_B]);

  p_pulse_flag_r12: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> busErr);
endmodule

bind bridge_ctl_reg bridge_ctl_reg_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cpuSel       (cpuSel),
  .cpuWr        (cpuWr),
  .hostSel      (hostSel),
  .hostWr       (hostWr),
  .cpuRdata     (cpuRdata),
  .hostRdata    (hostRdata),
  .modeHostOnly (modeHostOnly),
  .modeChgErr   (modeChgErr),
  .toHit        (toHit),
  .timeoutLimit (timeoutLimit),
  .waitStrobe2  (waitStrobe2),
  .waitStrobe1  (waitStrobe1),
  .cpuPriority  (cpuPriority),
  .busErr       (busErr),
  .errPulse     (errPulse)
);

// File: tb/bridge_ctl_reg_test.sv
module bridge_ctl_reg_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuSel = 1'b0, cpuWr = 1'b0;
  logic [15:0] cpuWdata = '0;
  logic [15:0] cpuRdata, hostRdata;
  logic        hostSel = 1'b0, hostWr = 1'b0;
  logic        modeHostOnly = 1'b1;
  logic        accStart = 1'b0, strobeTick = 1'b0, accDone = 1'b0, modeChgErr = 1'b0;
  logic [6:0]  timeoutLimit;
  logic [2:0]  waitStrobe2, waitStrobe1;
  logic        cpuPriority, busErr, errPulse;

  int errors = 0;
  int checks = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  bridge_ctl_reg uut (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .hostSel(hostSel),
    .hostWr(hostWr), .hostRdata(hostRdata), .modeHostOnly(modeHostOnly),
    .accStart(accStart), .strobeTick(strobeTick), .accDone(accDone),
    .modeChgErr(modeChgErr), .timeoutLimit(timeoutLimit),
    .waitStrobe2(waitStrobe2), .waitStrobe1(waitStrobe1),
    .cpuPriority(cpuPriority), .busErr(busErr), .errPulse(errPulse)
  );

  // Monitor: compares each CPU read against the expected item queued by the driver
  always @(negedge clk) begin
    if (rstN && cpuSel && !cpuWr) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read, actual=%h expected=none", cpuRdata);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (cpuRdata !== e) begin
          errors++;
          $display("FAIL %s: cpuRdata actual=%h expected=%h", t, cpuRdata, e);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Each drive task occupies one cycle, starting just after a rising edge
  task automatic nextCycle();
    @(posedge clk);
    #2;
    cpuSel = 1'b0; cpuWr = 1'b0; hostSel = 1'b0; hostWr = 1'b0;
    accStart = 1'b0; strobeTick = 1'b0; accDone = 1'b0; modeChgErr = 1'b0;
  endtask

  task automatic cpuRead(input logic [15:0] exp, input string tag, input logic err = 1'b0);
    nextCycle();
    expQ.push_back(exp);
    tagQ.push_back(tag);
    cpuSel = 1'b1;
    modeChgErr = err;
  endtask

  task automatic cpuWrite(input logic [15:0] d);
    nextCycle();
    cpuSel = 1'b1; cpuWr = 1'b1; cpuWdata = d;
  endtask

  task automatic hostRead(input logic [15:0] exp, input string tag);
    nextCycle();
    hostSel = 1'b1;
    #1;
    check(tag, hostRdata, exp);
  endtask

  task automatic acc(input logic st, input logic tk, input logic dn);
    nextCycle();
    accStart = st; strobeTick = tk; accDone = dn;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R1 reset state
    cpuRead(16'hFE4D, "R1 cpu reset word");
    hostRead(16'hFE4D, "R1 host reset word");
    check("R1 fields", {timeoutLimit, waitStrobe2, waitStrobe1, cpuPriority},
          {2'b0, 7'h7F, 3'd1, 3'd1, 1'b1});
    check("R1 flags", {busErr, errPulse}, 16'h0);

    // R4 host writes ignored
    nextCycle(); hostSel = 1'b1; hostWr = 1'b1;
    nextCycle();
    check("R4 fields", {timeoutLimit, waitStrobe2, waitStrobe1, cpuPriority},
          {2'b0, 7'h7F, 3'd1, 3'd1, 1'b1});
    hostRead(16'hFE4D, "R4 host readback");

    // R5 mode follows input after one edge
    modeHostOnly = 1'b0;
    nextCycle();
    cpuRead(16'hFE4C, "R5 mode cleared");

    // R2 / R3 write: limit 3, ws2 2, ws1 5, pri 0, low bits 11
    cpuWrite(16'h06AB);
    nextCycle();
    check("R2 fields", {timeoutLimit, waitStrobe2, waitStrobe1, cpuPriority},
          {2'b0, 7'd3, 3'd2, 3'd5, 1'b0});
    cpuRead(16'h06A8, "R3 low bits ignored");

    // R6 timeout after 3 ticks
    acc(1, 0, 0);
    acc(0, 1, 0);
    acc(0, 1, 0);
    acc(0, 1, 0);
    acc(0, 0, 0);
    check("R6 no error before limit", {busErr, errPulse}, 16'h0);
    nextCycle();
    check("R6 timeout error", {busErr, errPulse}, 16'h3);
    nextCycle();
    check("R12 pulse one cycle", {busErr, errPulse}, 16'h2);

    // R9 read returns flag then clears it
    cpuRead(16'h06AA, "R9 flag visible");
    cpuRead(16'h06A8, "R9 flag cleared");
    nextCycle();
    check("R9 busErr port", {15'b0, busErr}, 16'h0);

    // R7 completion before limit
    acc(1, 0, 0);
    acc(0, 1, 0);
    acc(0, 1, 0);
    acc(0, 0, 1);
    acc(0, 1, 0);
    acc(0, 1, 0);
    nextCycle();
    nextCycle();
    check("R7 no error after done", {busErr, errPulse}, 16'h0);

    // R8 mode-change error
    nextCycle(); modeChgErr = 1'b1;
    nextCycle();
    check("R8 mode err sets", {busErr, errPulse}, 16'h3);
    nextCycle();
    check("R12 pulse ends", {busErr, errPulse}, 16'h2);

    // R10 read and error together: flag stays
    cpuRead(16'h06AA, "R10 read with event", 1'b1);
    cpuRead(16'h06AA, "R10 set wins");
    cpuRead(16'h06A8, "R10 later clear");

    // R11 masking in host-only mode
    nextCycle(); modeChgErr = 1'b1;
    modeHostOnly = 1'b1;
    nextCycle();
    hostRead(16'h06A9, "R11 masked in host-only");
    check("R11 flag held", {15'b0, busErr}, 16'h1);
    modeHostOnly = 1'b0;
    nextCycle();
    hostRead(16'h06AA, "R11 unmasked");

    // R6 zero limit fires without ticks
    cpuRead(16'h06AA, "R9 clear before zero limit");
    cpuWrite(16'h00A8);
    acc(1, 0, 0);
    acc(0, 0, 0);
    check("R6 zero limit not yet", {busErr, errPulse}, 16'h0);
    nextCycle();
    check("R6 zero limit fires", {busErr, errPulse}, 16'h3);

    nextCycle();
    nextCycle();
    if (expQ.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", expQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule